// File: doc/BRIEF.md
# Mode Transition Request Validator

This block screens every software write that asks the device to move to another operating mode. Each write carries a 4-bit target mode code and a 16-bit key word. The block looks at the write together with the current mode, the parent mode, a transition-busy flag, a per-mode enable mask, a low-power-exit-failure flag and the hardware SAFE request from the reset controller. From these it either passes a one-cycle request for the target mode to the transition sequencer, or it records exactly one of five sticky cause bits.

Some causes are detected on any write. The others are detected only when the write completes a correct key pair. The block keeps an invalid-request pending bit and a SAFE-entry pending bit, and it drives a maskable interrupt line for each.

Mode codes: RESET=0, TEST=1, SAFE=2, BOOT=3, RUN0..RUN3=4..7, HALT=8, STOP=10, STANDBY=13. The existence set is the `EXIST_MASK` parameter, which by default holds exactly these codes. Cause bits in `cause_status`: bit 4 safe-event-active, bit 3 absent mode, bit 2 disabled mode, bit 1 illegal target, bit 0 busy.

Top module: `mode_req_validator`

## Requirements
- R1: A write whose mode code is not in the existence set sets cause bit 3, whatever its key. No request is ever issued for such a code.
- R2: A write whose target is cleared in `mode_en` sets cause bit 2, whatever its key. RESET and SAFE count as enabled regardless of `mode_en`.
- R3: While `hw_safe_req` is high, a write for any target other than RESET or SAFE sets cause bit 4, whatever its key.
- R4: A key pair is two consecutive writes with the same mode code. The first carries `KEY_VAL` and the second carries `~KEY_VAL`. A pair whose mode codes differ is discarded. An accepted pair drives `req_valid` high for the one cycle after the second write, with `req_mode` set to the target.
- R5: A keyed request whose target is not a legal successor of the current mode sets cause bit 1. Legal successors are: RESET→BOOT/TEST; TEST→BOOT; SAFE→BOOT/RUNx; BOOT→TEST/RUNx; RUNx→BOOT/RUNx/HALT/STOP/STANDBY; HALT or STOP→RUNx; STANDBY→BOOT. The same write without a key pair is ignored.
- R6: A keyed, otherwise legal request made while `in_progress` is high sets cause bit 0. The same write without a key pair is ignored.
- R7: When several causes apply to one write, only the highest-priority bit is recorded. The order is bit 4, then 3, 2, 1, 0.
- R8: Keyed requests for RESET or SAFE are always accepted.
- R9: While a transition is busy, three keyed requests are still accepted: a self-transition, a request for `parent_mode`, and a request from HALT or STOP to any RUNx.
- R10: While `lp_exit_fail` is high, every keyed target other than RESET or SAFE sets cause bit 1. This includes self and parent targets.
- R11: Every recorded cause sets `imode_pend`. `irq_imode` is high exactly when `imode_pend` and `mask_imode` are both high.
- R12: A rising edge of `hw_safe_req` sets `safe_pend`, and this holds in any current mode, SAFE included. `clr_safe` clears `safe_pend` only while `hw_safe_req` is low. `irq_safe` equals `safe_pend` AND `mask_safe`.
- R13: The cause bits, `imode_pend` and `safe_pend` are write-1-to-clear through `clr_cause`, `clr_imode` and `clr_safe`. Bits not written with 1 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Mode-request write strobe |
| wr_mode | input | 4 | Target mode code of the write |
| wr_key | input | KEY_W | Key word of the write |
| cur_mode | input | 4 | Current mode |
| parent_mode | input | 4 | Mode before the last accepted request |
| in_progress | input | 1 | Transition busy |
| lp_exit_fail | input | 1 | Low-power exit did not complete |
| mode_en | input | 16 | Per-mode enable mask |
| hw_safe_req | input | 1 | Hardware SAFE request |
| clr_cause | input | 5 | W1C for cause bits |
| clr_imode | input | 1 | W1C for imode_pend |
| clr_safe | input | 1 | W1C for safe_pend |
| mask_imode | input | 1 | Invalid-request interrupt mask |
| mask_safe | input | 1 | SAFE interrupt mask |
| req_valid | output | 1 | Accepted request pulse |
| req_mode | output | 4 | Accepted target mode |
| cause_status | output | 5 | Sticky cause bits |
| imode_pend | output | 1 | Invalid-request pending |
| safe_pend | output | 1 | SAFE-entry pending |
| irq_imode | output | 1 | Invalid-request interrupt |
| irq_safe | output | 1 | SAFE-entry interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit key, the eleven-code existence mask and set-wins-over-clear. An enable mask that disables RUN3, STANDBY, RESET and SAFE keeps the forced-enable rule in play. This small configuration makes an exhaustive sweep affordable. Every current mode and every target code is crossed with every combination of busy, low-power-exit failure and hardware SAFE request, so each priority overlap and each exception meets every other. Directed sequences then cover the unkeyed and mismatched writes, the partial clears, the masking and the SAFE pending lifecycle.

// File: rtl/mtv_pkg.sv
`timescale 1ns/1ps
package mtv_pkg;
   localparam int MODE_W    = 4;
   localparam int NUM_MODES = 1 << MODE_W;
   localparam int NUM_CAUSE = 5;

   typedef logic [MODE_W-1:0] mode_t;

   localparam mode_t MD_RESET = 4'd0;
   localparam mode_t MD_TEST  = 4'd1;
   localparam mode_t MD_SAFE  = 4'd2;
   localparam mode_t MD_BOOT  = 4'd3;
   localparam mode_t MD_RUN0  = 4'd4;
   localparam mode_t MD_RUN3  = 4'd7;
   localparam mode_t MD_HALT  = 4'd8;
   localparam mode_t MD_STOP  = 4'd10;
   localparam mode_t MD_STBY  = 4'd13;

   // cause bit positions, highest priority first
   localparam int CB_SAFE_EVT = 4;
   localparam int CB_ABSENT   = 3;
   localparam int CB_DISABLED = 2;
   localparam int CB_ILLEGAL  = 1;
   localparam int CB_BUSY     = 0;

   typedef logic [NUM_CAUSE-1:0] cause_t;

   function automatic logic is_run(mode_t m);
      return (m >= MD_RUN0) && (m <= MD_RUN3);
   endfunction

   function automatic logic is_lowpwr(mode_t m);
      return (m == MD_HALT) || (m == MD_STOP);
   endfunction

   function automatic logic is_escape(mode_t m);
      return (m == MD_RESET) || (m == MD_SAFE);
   endfunction
endpackage

// File: rtl/mtv_keyseq.sv
`timescale 1ns/1ps
module mtv_keyseq
   import mtv_pkg::*;
#(
   parameter int              KEY_W   = 16,
   parameter logic [KEY_W-1:0] KEY_VAL = 16'hA5C3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  mode_t            wr_mode,
   input  logic [KEY_W-1:0] wr_key,
   input  logic             abort,
   output logic             keyed
);
   localparam logic [KEY_W-1:0] KEY_INV = ~KEY_VAL;

   logic  armed_q;
   mode_t armed_mode_q;
   logic  is_first, is_second;

   assign is_first  = (wr_key == KEY_VAL);
   assign is_second = (wr_key == KEY_INV);
   assign keyed     = wr_en && armed_q && is_second && (wr_mode == armed_mode_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q      <= 1'b0;
         armed_mode_q <= '0;
      end else if (wr_en) begin
         armed_q      <= is_first && !abort;
         armed_mode_q <= wr_mode;
      end
   end

   // a completed pair always disarms the tracker
   assert_pair_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
      keyed |=> !armed_q);
endmodule

// File: rtl/mtv_rules.sv
`timescale 1ns/1ps
module mtv_rules
   import mtv_pkg::*;
#(
   parameter logic [NUM_MODES-1:0] EXIST_MASK = 16'h25FF
)(
   input  mode_t                 tgt,
   input  mode_t                 cur_mode,
   input  mode_t                 parent_mode,
   input  logic                  in_progress,
   input  logic                  lp_exit_fail,
   input  logic                  hw_safe_req,
   input  logic [NUM_MODES-1:0]  mode_en,
   input  logic                  keyed,
   output cause_t                keyless_cause,
   output cause_t                keyed_cause,
   output logic                  accept
);
   localparam logic [NUM_MODES-1:0] FORCED_ON =
      (NUM_MODES'(1) << MD_RESET) | (NUM_MODES'(1) << MD_SAFE);

   logic [NUM_MODES-1:0] en_eff;
   logic [NUM_MODES-1:0] succ;
   logic                 tgt_esc;

   assign en_eff  = (mode_en & EXIST_MASK) | FORCED_ON;
   assign tgt_esc = is_escape(tgt);

   function automatic logic [NUM_MODES-1:0] succ_of(mode_t c);
      logic [NUM_MODES-1:0] m;
      logic [NUM_MODES-1:0] runs;
      runs = '0;
      for (int r = MD_RUN0; r <= MD_RUN3; r++) runs[r] = 1'b1;
      m = '0;
      case (c)
         MD_RESET: begin m[MD_BOOT] = 1'b1; m[MD_TEST] = 1'b1; end
         MD_TEST:  m[MD_BOOT] = 1'b1;
         MD_SAFE:  begin m = runs; m[MD_BOOT] = 1'b1; end
         MD_BOOT:  begin m = runs; m[MD_TEST] = 1'b1; end
         MD_HALT, MD_STOP: m = runs;
         MD_STBY:  m[MD_BOOT] = 1'b1;
         default: begin
            if (is_run(c)) begin
               m = runs;
               m[MD_BOOT] = 1'b1;
               m[MD_HALT] = 1'b1;
               m[MD_STOP] = 1'b1;
               m[MD_STBY] = 1'b1;
            end
         end
      endcase
      return m;
   endfunction

   assign succ = succ_of(cur_mode);

   // causes visible on any write
   always_comb begin
      keyless_cause = '0;
      if (hw_safe_req && !tgt_esc)  keyless_cause[CB_SAFE_EVT] = 1'b1;
      else if (!EXIST_MASK[tgt])    keyless_cause[CB_ABSENT]   = 1'b1;
      else if (!en_eff[tgt])        keyless_cause[CB_DISABLED] = 1'b1;
   end

   // causes and acceptance that need a completed key pair
   always_comb begin
      keyed_cause = '0;
      accept      = 1'b0;
      if (keyed && (keyless_cause == '0)) begin
         if (tgt_esc)                                 accept = 1'b1;
         else if (lp_exit_fail)                       keyed_cause[CB_ILLEGAL] = 1'b1;
         else if (tgt == cur_mode)                    accept = 1'b1;
         else if (in_progress && tgt == parent_mode)  accept = 1'b1;
         else if (!succ[tgt])                         keyed_cause[CB_ILLEGAL] = 1'b1;
         else if (in_progress && !(is_lowpwr(cur_mode) && is_run(tgt)))
                                                      keyed_cause[CB_BUSY] = 1'b1;
         else                                         accept = 1'b1;
      end
   end

   always_comb begin
      assert_single_cause_R7: assert ($onehot0(keyless_cause | keyed_cause));
      assert_accept_excl_R7:  assert (!(accept && ((keyless_cause | keyed_cause) != '0)));
   end
endmodule

// File: rtl/mtv_status.sv
`timescale 1ns/1ps
module mtv_status
   import mtv_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
)(
   input  logic   clk,
   input  logic   rst_n,
   input  cause_t ev_cause,
   input  cause_t clr_cause,
   input  logic   clr_imode,
   input  logic   hw_safe_req,
   input  logic   clr_safe,
   input  logic   mask_imode,
   input  logic   mask_safe,
   output cause_t cause_status,
   output logic   imode_pend,
   output logic   safe_pend,
   output logic   irq_imode,
   output logic   irq_safe
);
   for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_bit
      logic q;
      if (SET_WINS) begin : g_setwins
         always_ff @(posedge clk) begin
            if (!rst_n)            q <= 1'b0;
            else if (ev_cause[i])  q <= 1'b1;
            else if (clr_cause[i]) q <= 1'b0;
         end
      end else begin : g_clrwins
         always_ff @(posedge clk) begin
            if (!rst_n)            q <= 1'b0;
            else if (clr_cause[i]) q <= 1'b0;
            else if (ev_cause[i])  q <= 1'b1;
         end
      end
      assign cause_status[i] = q;
   end

   logic any_ev;
   assign any_ev = |ev_cause;

   always_ff @(posedge clk) begin
      if (!rst_n)         imode_pend <= 1'b0;
      else if (any_ev)    imode_pend <= 1'b1;
      else if (clr_imode) imode_pend <= 1'b0;
   end

   logic hw_safe_q, hw_rise;
   assign hw_rise = hw_safe_req && !hw_safe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hw_safe_q <= 1'b0;
         safe_pend <= 1'b0;
      end else begin
         hw_safe_q <= hw_safe_req;
         if (hw_rise)                       safe_pend <= 1'b1;
         else if (clr_safe && !hw_safe_req) safe_pend <= 1'b0;
      end
   end

   assign irq_imode = imode_pend & mask_imode;
   assign irq_safe  = safe_pend & mask_safe;

   assert_new_cause_pends_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_status & ~$past(cause_status)) != '0) |-> imode_pend);

   assert_safe_pend_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hw_safe_req) && $past(safe_pend)) |-> safe_pend);

   assert_safe_rise_sets_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hw_safe_req) |=> safe_pend);
endmodule

// File: rtl/mode_req_validator.sv
`timescale 1ns/1ps
module mode_req_validator
   import mtv_pkg::*;
#(
   parameter int                   KEY_W      = 16,
   parameter logic [KEY_W-1:0]     KEY_VAL    = 16'hA5C3,
   parameter logic [NUM_MODES-1:0] EXIST_MASK = 16'h25FF,
   parameter bit                   SET_WINS   = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [MODE_W-1:0]    wr_mode,
   input  logic [KEY_W-1:0]     wr_key,
   input  logic [MODE_W-1:0]    cur_mode,
   input  logic [MODE_W-1:0]    parent_mode,
   input  logic                 in_progress,
   input  logic                 lp_exit_fail,
   input  logic [NUM_MODES-1:0] mode_en,
   input  logic                 hw_safe_req,
   input  logic [NUM_CAUSE-1:0] clr_cause,
   input  logic                 clr_imode,
   input  logic                 clr_safe,
   input  logic                 mask_imode,
   input  logic                 mask_safe,
   output logic                 req_valid,
   output logic [MODE_W-1:0]    req_mode,
   output logic [NUM_CAUSE-1:0] cause_status,
   output logic                 imode_pend,
   output logic                 safe_pend,
   output logic                 irq_imode,
   output logic                 irq_safe
);
   initial begin : elab_chk
      assert (KEY_W >= 8) else $error("KEY_W must be at least 8");
      assert (EXIST_MASK[MD_RESET] && EXIST_MASK[MD_SAFE])
         else $error("RESET and SAFE must exist");
   end

   logic   keyed, accept, kl_fail;
   cause_t kl_cause, kd_cause, ev_cause;

   mtv_keyseq #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_key (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
      .wr_key(wr_key), .abort(kl_fail), .keyed(keyed)
   );

   mtv_rules #(.EXIST_MASK(EXIST_MASK)) u_rules (
      .tgt(wr_mode), .cur_mode(cur_mode), .parent_mode(parent_mode),
      .in_progress(in_progress), .lp_exit_fail(lp_exit_fail),
      .hw_safe_req(hw_safe_req), .mode_en(mode_en), .keyed(keyed),
      .keyless_cause(kl_cause), .keyed_cause(kd_cause), .accept(accept)
   );

   assign kl_fail  = wr_en && (kl_cause != '0);
   assign ev_cause = (wr_en ? kl_cause : '0) | kd_cause;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_mode  <= '0;
      end else begin
         req_valid <= accept;
         if (accept) req_mode <= wr_mode;
      end
   end

   mtv_status #(.SET_WINS(SET_WINS)) u_stat (
      .clk(clk), .rst_n(rst_n), .ev_cause(ev_cause), .clr_cause(clr_cause),
      .clr_imode(clr_imode), .hw_safe_req(hw_safe_req), .clr_safe(clr_safe),
      .mask_imode(mask_imode), .mask_safe(mask_safe),
      .cause_status(cause_status), .imode_pend(imode_pend),
      .safe_pend(safe_pend), .irq_imode(irq_imode), .irq_safe(irq_safe)
   );

   assert_req_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $past(wr_en));

   assert_req_mode_exists_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> EXIST_MASK[req_mode]);

   assert_escape_accepted_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (keyed && is_escape(wr_mode)) |=> (req_valid && req_mode == $past(wr_mode)));
endmodule

// File: tb/mode_req_validator_test.sv
`timescale 1ns/1ps
module mode_req_validator_test;
   localparam logic [15:0] KEY  = 16'hA5C3;
   localparam logic [15:0] EXM  = 16'h25FF;
   localparam logic [15:0] ENM  = 16'h057A; // RUN3, STANDBY, RESET, SAFE cleared

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [3:0] wr_mode = '0;
   logic [15:0] wr_key = '0;
   logic [3:0] cur_mode = '0, parent_mode = '0;
   logic in_progress = 1'b0, lp_exit_fail = 1'b0, hw_safe_req = 1'b0;
   logic [15:0] mode_en = ENM;
   logic [4:0] clr_cause = '0;
   logic clr_imode = 1'b0, clr_safe = 1'b0, mask_imode = 1'b1, mask_safe = 1'b1;
   logic req_valid, imode_pend, safe_pend, irq_imode, irq_safe;
   logic [3:0] req_mode;
   logic [4:0] cause_status;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   mode_req_validator uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode), .wr_key(wr_key),
      .cur_mode(cur_mode), .parent_mode(parent_mode), .in_progress(in_progress),
      .lp_exit_fail(lp_exit_fail), .mode_en(mode_en), .hw_safe_req(hw_safe_req),
      .clr_cause(clr_cause), .clr_imode(clr_imode), .clr_safe(clr_safe),
      .mask_imode(mask_imode), .mask_safe(mask_safe), .req_valid(req_valid),
      .req_mode(req_mode), .cause_status(cause_status), .imode_pend(imode_pend),
      .safe_pend(safe_pend), .irq_imode(irq_imode), .irq_safe(irq_safe)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit exists(int m); return EXM[m]; endfunction
   function automatic bit isrun(int m); return m >= 4 && m <= 7; endfunction
   function automatic bit may_go(int c, int t);
      if (c == 0) return t == 3 || t == 1;
      if (c == 1) return t == 3;
      if (c == 2) return t == 3 || isrun(t);
      if (c == 3) return t == 1 || isrun(t);
      if (isrun(c)) return t == 3 || isrun(t) || t == 8 || t == 10 || t == 13;
      if (c == 8 || c == 10) return isrun(t);
      if (c == 13) return t == 3;
      return 1'b0;
   endfunction

   // returns {accept, cause[4:0]} for a complete key pair
   function automatic logic [5:0] model(int c, int t, int p, bit ip, bit lp, bit hs);
      bit esc = (t == 0 || t == 2);
      bit en  = esc || (ENM[t] && exists(t));
      if (hs && !esc)          return 6'b0_10000;
      if (!exists(t))          return 6'b0_01000;
      if (!en)                 return 6'b0_00100;
      if (esc)                 return 6'b1_00000;
      if (lp)                  return 6'b0_00010;
      if (t == c)              return 6'b1_00000;
      if (ip && t == p)        return 6'b1_00000;
      if (!may_go(c, t))       return 6'b0_00010;
      if (ip && !((c == 8 || c == 10) && isrun(t))) return 6'b0_00001;
      return 6'b1_00000;
   endfunction

   task automatic clear_all();
      @(negedge clk);
      clr_cause = '1; clr_imode = 1'b1; clr_safe = 1'b1;
      @(negedge clk);
      clr_cause = '0; clr_imode = 1'b0; clr_safe = 1'b0;
   endtask

   task automatic wr(input logic [3:0] m, input logic [15:0] k);
      @(negedge clk);
      wr_en = 1'b1; wr_mode = m; wr_key = k;
   endtask

   task automatic wr_done();
      @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [5:0] e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R4 reset req_valid", 16'(req_valid), 0);
      chk("R13 reset cause", 16'(cause_status), 0);
      chk("R11 reset imode_pend", 16'(imode_pend), 0);
      chk("R12 reset safe_pend", 16'(safe_pend), 0);

      // exhaustive sweep R1 R2 R3 R5 R6 R7 R8 R9 R10 R11
      parent_mode = 4'd6;
      for (int c = 0; c < 16; c++)
         for (int t = 0; t < 16; t++)
            for (int s = 0; s < 8; s++) begin
               @(negedge clk);
               cur_mode = 4'(c); in_progress = s[0]; lp_exit_fail = s[1];
               hw_safe_req = s[2];
               clr_cause = '1; clr_imode = 1'b1;
               wr(4'(t), KEY);
               clr_cause = '0; clr_imode = 1'b0;
               wr(4'(t), ~KEY);
               wr_done();
               wr_en = 1'b0;
               e = model(c, t, 6, s[0], s[1], s[2]);
               chk("R4/R8/R9 sweep req_valid", 16'(req_valid), 16'(e[5]));
               if (e[5]) chk("R4 sweep req_mode", 16'(req_mode), 16'(t));
               chk("R1/R2/R3/R5/R6/R7/R10 sweep cause", 16'(cause_status), 16'(e[4:0]));
               chk("R11 sweep irq_imode", 16'(irq_imode), 16'(e[4:0] != 0));
            end
      in_progress = 0; lp_exit_fail = 0; hw_safe_req = 0;
      clear_all();

      // R5: unkeyed illegal target ignored (RESET -> RUN0)
      cur_mode = 4'd0;
      wr(4'd4, ~KEY); wr_done(); wr_en = 1'b0;
      chk("R5 unkeyed illegal cause", 16'(cause_status), 0);
      chk("R5 unkeyed illegal req", 16'(req_valid), 0);

      // R6: unkeyed request while busy ignored (RUN0 -> RUN1)
      cur_mode = 4'd4; in_progress = 1'b1;
      wr(4'd5, 16'h1234); wr_done(); wr_en = 1'b0;
      chk("R6 unkeyed busy cause", 16'(cause_status), 0);
      in_progress = 1'b0;

      // R4: mismatched mode codes in a pair are discarded
      wr(4'd5, KEY); wr(4'd6, ~KEY); wr_done(); wr_en = 1'b0;
      chk("R4 mismatch req", 16'(req_valid), 0);
      chk("R4 mismatch cause", 16'(cause_status), 0);
      // a proper pair afterwards is accepted
      wr(4'd6, KEY); wr(4'd6, ~KEY); wr_done(); wr_en = 1'b0;
      chk("R4 good pair req", 16'(req_valid), 1);
      chk("R4 good pair mode", 16'(req_mode), 6);
      @(negedge clk);
      chk("R4 pulse one cycle", 16'(req_valid), 0);

      // R1 and R2 without key; then partial W1C (R13)
      wr(4'd9, 16'h0); wr(4'd7, 16'h0); wr_done(); wr_en = 1'b0;
      chk("R1/R2 unkeyed causes", 16'(cause_status), 16'b01100);
      @(negedge clk); clr_cause = 5'b01000;
      @(negedge clk); clr_cause = '0;
      chk("R13 partial clear", 16'(cause_status), 16'b00100);
      // R11 masking
      mask_imode = 1'b0; @(negedge clk);
      chk("R11 masked irq", 16'(irq_imode), 0);
      chk("R11 pend held", 16'(imode_pend), 1);
      mask_imode = 1'b1; @(negedge clk);
      chk("R11 unmasked irq", 16'(irq_imode), 1);
      clr_imode = 1'b1; @(negedge clk); clr_imode = 1'b0;
      chk("R13 imode clear", 16'(imode_pend), 0);
      chk("R13 cause kept", 16'(cause_status), 16'b00100);

      // R12 SAFE pending lifecycle
      hw_safe_req = 1'b1; @(negedge clk);
      chk("R12 rise sets", 16'(safe_pend), 1);
      chk("R12 irq_safe", 16'(irq_safe), 1);
      clr_safe = 1'b1; @(negedge clk); clr_safe = 1'b0;
      chk("R12 clear blocked", 16'(safe_pend), 1);
      hw_safe_req = 1'b0; clr_safe = 1'b1; @(negedge clk); clr_safe = 1'b0;
      chk("R12 clear after drop", 16'(safe_pend), 0);
      cur_mode = 4'd2; hw_safe_req = 1'b1; @(negedge clk);
      chk("R12 set while in SAFE", 16'(safe_pend), 1);
      mask_safe = 1'b0; @(negedge clk);
      chk("R12 masked irq_safe", 16'(irq_safe), 0);
      hw_safe_req = 1'b0;

      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule